// File: doc/BRIEF.md
# Codec Register Access Controller over I2C

This block is a bus master that reads and writes single registers in an audio codec attached to a two-wire I2C bus. Each codec register has a 7-bit address and holds a 9-bit value. The value does not fit in one byte. Its most significant bit therefore travels as the least significant bit of the register byte, and a second byte carries the remaining eight bits. The host places a device address, a register address, write data and a direction on the request pins, then pulses `start` for one cycle. It then waits for `done`. When `done` pulses, `nack_err` and `rdata` are valid.

The bus pins are open-drain. The block never drives a line high. `scl_oe` and `sda_oe` high mean that the line is pulled low, and the external pull-ups supply the high level. `sda_in` returns the resolved state of the data line. Each bit is split into four quarter phases of `clk_div+1` system cycles each:
- SCL falls.
- SDA changes at mid-low.
- SCL rises.
- SDA is sampled at mid-high.

`clk_div` must be at least 2. The request interface is a plain strobe with no back-pressure. Any `start` that arrives while `busy` is high is dropped, so the host must wait for `done` before it issues the next request.

Top module: `ci2c_codec_master`

## Requirements
- R1: A write sends these items in order: START, then the byte {dev_addr, 0}, then the register byte {reg_addr, wdata[8]}, then the byte wdata[7:0], then STOP. Every byte goes out most significant bit first, and each byte is followed by an acknowledge clock.
- R2: SDA changes only while SCL is low, with two exceptions: SDA falls with SCL high (START) and SDA rises with SCL high (STOP). `scl_oe` and `sda_oe` never change in the same cycle. A completed write shows exactly one START and one STOP. A completed read shows two STARTs and one STOP.
- R3: A read sends these items in order:
  - START, then {dev_addr, 0}, then the register byte {reg_addr, 0}.
  - A repeated START, then {dev_addr, 1}.
  - Two received bytes. The master answers ACK (SDA low) after the first byte and NACK (SDA released) after the second.
  - STOP.
- R4: After a read completes, `rdata` = {first_byte[0], second_byte[7:0]}. `rdata` changes only in the cycle that `done` is high, and only when a read completed with no NACK.
- R5: A high SDA on any acknowledge clock of a byte sent by the master ends the transfer. No further bytes are sent, a STOP follows, and `done` pulses.
- R6: `nack_err` rises only in the cycle that `done` is high, and only when a NACK was seen. It clears in the cycle after the next accepted `start`.
- R7: A `start` pulse while `busy` is high has no effect. It starts no transfer and does not alter the transfer in progress.
- R8: `busy` is high in the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle that `busy` falls.
- R9: During a transfer, every SCL high pulse lasts exactly 2*(clk_div+1) system cycles.
- R10: After reset, `busy`, `done`, `nack_err` and `rdata` are 0. Whenever `busy` is low, both `scl_oe` and `sda_oe` are 0, which releases the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Length of a quarter bit, in system cycles minus one (at least 2) |
| start | input | 1 | One-cycle request strobe |
| rnw | input | 1 | 1 = read register, 0 = write register |
| dev_addr | input | 7 | Codec device address |
| reg_addr | input | 7 | Codec register address |
| wdata | input | 9 | Register value to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| nack_err | output | 1 | Last transfer saw a NACK |
| rdata | output | 9 | Register value from the last successful read |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |
| sda_in | input | 1 | Resolved data line level |

## Verification
`busy` is due one cycle after the edge that accepts `start`. `nack_err`, `rdata` and the released bus lines are due in the cycle that `done` pulses. That cycle comes one cycle after the edge at which SDA is released for STOP. Every bus bit spans 4*(clk_div+1) cycles, so the exact arrival time of `done` depends on `clk_div` and on where a NACK cuts the frame short.

The bench changes inputs and samples outputs on falling clock edges. It reads `busy` on the first falling edge after the accept edge. It polls for `done` and compares the results in that same cycle. It confirms on the next falling edge that `done` has dropped. A bus-side responder counts SCL high samples, so the per-bit timing is checked in whole cycles.

// File: rtl/ci2c_pkg.sv
package ci2c_pkg;
  localparam int DEV_W = 7;
  localparam int REG_W = 7;
  localparam int VAL_W = 9;
  localparam int BYTE_W = REG_W + 1;

  typedef enum logic [1:0] {
    OP_BIT  = 2'd0,
    OP_RST  = 2'd1,
    OP_STOP = 2'd2
  } bus_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE   = 4'd0,
    SQ_START  = 4'd1,
    SQ_TX     = 4'd2,
    SQ_TACK   = 4'd3,
    SQ_RSTART = 4'd4,
    SQ_RX     = 4'd5,
    SQ_MACK   = 4'd6,
    SQ_STOP   = 4'd7
  } seq_st_e;
endpackage

// File: rtl/ci2c_quarter_tick.sv
module ci2c_quarter_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // Free-running down counter: one tick every div+1 cycles.
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == '0)    cnt <= div;
    else                   cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/ci2c_bit_engine.sv
module ci2c_bit_engine
  import ci2c_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    go,
  input  bus_op_e op,
  input  logic    tx_bit,
  input  logic    sda_in,
  output logic    fin,
  output logic    rx_bit,
  output logic    scl_oe,
  output logic    sda_oe
);
  logic    active;
  logic [1:0] q;
  bus_op_e op_q;
  logic    bit_q;

  // Every operation is four quarters long:
  // q0 pull SCL low, q1 set SDA, q2 release SCL, q3 sample or make a condition.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      q      <= 2'd0;
      op_q   <= OP_BIT;
      bit_q  <= 1'b1;
      fin    <= 1'b0;
      rx_bit <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          q      <= 2'd0;
          op_q   <= op;
          bit_q  <= tx_bit;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (q)
          2'd0: scl_oe <= 1'b1;
          2'd1: begin
            case (op_q)
              OP_BIT:  sda_oe <= ~bit_q;
              OP_RST:  sda_oe <= 1'b0;
              default: sda_oe <= 1'b1;
            endcase
          end
          2'd2: scl_oe <= 1'b0;
          default: begin
            active <= 1'b0;
            fin    <= 1'b1;
            case (op_q)
              OP_BIT:  rx_bit <= sda_in;
              OP_RST:  sda_oe <= 1'b1;
              default: sda_oe <= 1'b0;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ci2c_sequencer.sv
module ci2c_sequencer
  import ci2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rnw,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic [REG_W-1:0] reg_addr,
  input  logic [VAL_W-1:0] wdata,
  input  logic             fin,
  input  logic             rx_bit,
  output logic             go,
  output bus_op_e          op,
  output logic             tx_bit,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic [VAL_W-1:0] rdata
);
  seq_st_e           st;
  logic              pend;
  logic [2:0]        bcnt;
  logic [BYTE_W-1:0] sh;
  logic [1:0]        tx_idx;
  logic              rx_first, hi_bit, rd_ok, err_pend, rnw_q;
  logic [DEV_W-1:0]  dev_q;
  logic [REG_W-1:0]  reg_q;
  logic [VAL_W-1:0]  wd_q;

  assign go = (st != SQ_IDLE) && !pend;

  always_comb begin
    op     = OP_BIT;
    tx_bit = 1'b1;
    case (st)
      SQ_START, SQ_RSTART: op = OP_RST;
      SQ_STOP:             op = OP_STOP;
      SQ_TX:               tx_bit = sh[BYTE_W-1];
      SQ_MACK:             tx_bit = ~rx_first;
      default:             tx_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SQ_IDLE; pend <= 1'b0; bcnt <= 3'd0; sh <= '0; tx_idx <= 2'd0;
      rx_first <= 1'b0; hi_bit <= 1'b0; rd_ok <= 1'b0; err_pend <= 1'b0;
      rnw_q <= 1'b0; dev_q <= '0; reg_q <= '0; wd_q <= '0;
      busy <= 1'b0; done <= 1'b0; nack_err <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (go) pend <= 1'b1;
      if (st == SQ_IDLE) begin
        if (start) begin
          rnw_q <= rnw; dev_q <= dev_addr; reg_q <= reg_addr; wd_q <= wdata;
          busy <= 1'b1; nack_err <= 1'b0; err_pend <= 1'b0; rd_ok <= 1'b0;
          st <= SQ_START;
        end
      end else if (fin) begin
        pend <= 1'b0;
        case (st)
          SQ_START: begin
            sh <= {dev_q, 1'b0}; bcnt <= 3'd7; tx_idx <= 2'd0; st <= SQ_TX;
          end
          SQ_RSTART: begin
            sh <= {dev_q, 1'b1}; bcnt <= 3'd7; tx_idx <= 2'd2; st <= SQ_TX;
          end
          SQ_TX: begin
            sh <= {sh[BYTE_W-2:0], 1'b0};
            if (bcnt == 3'd0) st <= SQ_TACK;
            else              bcnt <= bcnt - 3'd1;
          end
          SQ_TACK: begin
            if (rx_bit) begin
              err_pend <= 1'b1;
              st <= SQ_STOP;
            end else begin
              bcnt <= 3'd7;
              case (tx_idx)
                2'd0: begin
                  // value MSB rides in the LSB of the register byte
                  sh <= {reg_q, rnw_q ? 1'b0 : wd_q[VAL_W-1]};
                  tx_idx <= 2'd1; st <= SQ_TX;
                end
                2'd1: begin
                  if (rnw_q) st <= SQ_RSTART;
                  else begin
                    sh <= wd_q[BYTE_W-1:0]; tx_idx <= 2'd2; st <= SQ_TX;
                  end
                end
                default: begin
                  if (rnw_q) begin
                    rx_first <= 1'b1; st <= SQ_RX;
                  end else st <= SQ_STOP;
                end
              endcase
            end
          end
          SQ_RX: begin
            sh <= {sh[BYTE_W-2:0], rx_bit};
            if (bcnt == 3'd0) st <= SQ_MACK;
            else              bcnt <= bcnt - 3'd1;
          end
          SQ_MACK: begin
            if (rx_first) begin
              hi_bit <= sh[0]; rx_first <= 1'b0; bcnt <= 3'd7; st <= SQ_RX;
            end else begin
              rd_ok <= 1'b1; st <= SQ_STOP;
            end
          end
          SQ_STOP: begin
            st <= SQ_IDLE; busy <= 1'b0; done <= 1'b1; nack_err <= err_pend;
            if (rd_ok) rdata <= {hi_bit, sh};
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ci2c_codec_master.sv
module ci2c_codec_master
  import ci2c_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             start,
  input  logic             rnw,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic [REG_W-1:0] reg_addr,
  input  logic [VAL_W-1:0] wdata,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic [VAL_W-1:0] rdata,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  logic    tick, go, tx_bit, fin, rx_bit;
  bus_op_e op;

  ci2c_quarter_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(clk_div), .tick(tick)
  );

  ci2c_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .op(op), .tx_bit(tx_bit),
    .sda_in(sda_in), .fin(fin), .rx_bit(rx_bit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  ci2c_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rnw(rnw), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .wdata(wdata), .fin(fin), .rx_bit(rx_bit), .go(go),
    .op(op), .tx_bit(tx_bit), .busy(busy), .done(done), .nack_err(nack_err),
    .rdata(rdata)
  );
endmodule

// File: rtl/ci2c_codec_master_chk.sv
module ci2c_codec_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       nack_err,
  input logic [8:0] rdata,
  input logic       scl_oe,
  input logic       sda_oe
);
  assert_edges_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe != $past(scl_oe)) |-> (sda_oe == $past(sda_oe)));

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_falls_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_err_only_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> done);

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind ci2c_codec_master ci2c_codec_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .nack_err(nack_err), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/ci2c_codec_master_test.sv
`timescale 1ns/1ps
module ci2c_codec_master_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, rnw;
  logic [15:0] clk_div;
  logic [6:0] dev, regs;
  logic [8:0] wd;
  logic busy, done, nack_err, scl_oe, sda_oe;
  logic [8:0] rdata;
  logic scl_line, sda_line, drv;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | drv);

  ci2c_codec_master uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start), .rnw(rnw),
    .dev_addr(dev), .reg_addr(regs), .wdata(wd), .busy(busy), .done(done),
    .nack_err(nack_err), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_line)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bus-side codec responder ----------------
  logic clr = 1'b0;
  int nack_at = 7;
  logic [7:0] rd_src [2];
  logic scl_p, sda_p, in_fr, rd, rd_next, hi_ok;
  logic [7:0] shf;
  logic [7:0] log_b [8];
  logic mack [2];
  int bitn, n_log, starts, stops, n_mack, rd_idx, fr_bytes, hw, hmin, hmax;

  always @(posedge clk) begin
    scl_p <= scl_line;
    sda_p <= sda_line;
    if (clr) begin
      in_fr <= 0; rd <= 0; rd_next <= 0; hi_ok <= 0; drv <= 0; bitn <= 0;
      n_log <= 0; starts <= 0; stops <= 0; n_mack <= 0; rd_idx <= 0;
      fr_bytes <= 0; hw <= 0; hmin <= 100000; hmax <= 0;
    end else begin
      if (in_fr && scl_line) hw <= hw + 1;
      if (in_fr && scl_line && !scl_p) begin
        hw <= 1; hi_ok <= 1;
        if (bitn < 8) begin
          if (!rd) shf <= {shf[6:0], sda_line};
          bitn <= bitn + 1;
        end else if (bitn == 8) begin
          if (rd && n_mack < 2) begin mack[n_mack] <= sda_line; n_mack <= n_mack + 1; end
          bitn <= 9;
        end
      end
      if (in_fr && !scl_line && scl_p) begin
        if (hi_ok) begin
          if (hw < hmin) hmin <= hw;
          if (hw > hmax) hmax <= hw;
        end
        if (bitn == 8) begin
          if (!rd) begin
            log_b[n_log] <= shf;
            n_log <= n_log + 1;
            drv <= (n_log != nack_at);
            if (fr_bytes == 0 && shf[0] && n_log != nack_at) rd_next <= 1;
            fr_bytes <= fr_bytes + 1;
          end else begin
            drv <= 0;
            rd_idx <= rd_idx + 1;
          end
        end else if (bitn == 9) begin
          bitn <= 0;
          if (rd || rd_next) begin
            rd <= 1;
            drv <= (rd_idx < 2) ? ~rd_src[rd_idx][7] : 1'b0;
          end else drv <= 0;
        end else if (rd && bitn >= 1) begin
          drv <= ~rd_src[rd_idx][7-bitn];
        end
      end
      if (scl_line && scl_p && sda_p && !sda_line) begin
        starts <= starts + 1; in_fr <= 1; bitn <= 0; rd <= 0; rd_next <= 0;
        drv <= 0; fr_bytes <= 0; hi_ok <= 0;
      end else if (scl_line && scl_p && !sda_p && sda_line) begin
        stops <= stops + 1; in_fr <= 0; drv <= 0;
      end
    end
  end

  // ---------------- vectors ----------------
  // {div[3:0], rnw, dev[6:0], reg[6:0], wdata[8:0], rd0[7:0], rd1[7:0], nack_at[2:0]} ; 7 = no NACK
  localparam int NV = 7;
  localparam logic [46:0] VEC [NV] = '{
    {4'd3, 1'b0, 7'h1A, 7'h05, 9'h15D, 8'h00, 8'h00, 3'd7},
    {4'd5, 1'b0, 7'h1A, 7'h7F, 9'h0A5, 8'h00, 8'h00, 3'd7},
    {4'd3, 1'b1, 7'h1A, 7'h03, 9'h000, 8'hFF, 8'h3C, 3'd7},
    {4'd2, 1'b1, 7'h55, 7'h2A, 9'h000, 8'h00, 8'hC3, 3'd7},
    {4'd3, 1'b0, 7'h1A, 7'h11, 9'h1FF, 8'h00, 8'h00, 3'd1},
    {4'd3, 1'b1, 7'h1A, 7'h11, 9'h000, 8'hA5, 8'h5A, 3'd2},
    {4'd4, 1'b0, 7'h33, 7'h40, 9'h100, 8'h00, 8'h00, 3'd0}
  };

  logic [8:0] exp_rd = 9'h0;

  task automatic run_txn(input logic [3:0] dv, input logic r, input logic [6:0] d,
                         input logic [6:0] ra, input logic [8:0] w,
                         input logic [7:0] b0, input logic [7:0] b1,
                         input int nk, input bit inject);
    logic [7:0] eb [3];
    int n_exp, st_exp, cyc, st_snap;
    bit ok;
    @(negedge clk);
    clk_div = {12'd0, dv}; rnw = r; dev = d; regs = ra; wd = w;
    rd_src[0] = b0; rd_src[1] = b1; nack_at = nk;
    start = 1; clr = 1;
    @(negedge clk);
    start = 0; clr = 0;
    check("R8 busy after start", busy, 1);
    check("R6 nack_err cleared on start", nack_err, 0);
    if (inject) begin
      repeat (40) @(negedge clk);
      start = 1; rnw = ~r; dev = ~d; regs = ~ra;
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (cyc >= 20000) check("watchdog waiting for done", 0, 1);
    ok = (nk > 2);
    eb[0] = {d, 1'b0};
    eb[1] = {ra, r ? 1'b0 : w[8]};
    eb[2] = r ? {d, 1'b1} : w[7:0];
    n_exp = ok ? 3 : nk + 1;
    st_exp = (r && nk >= 2) ? 2 : 1;
    if (r && ok) exp_rd = {b0[0], b1};
    check("R8 busy low at done", busy, 0);
    check("R5 R6 nack_err at done", nack_err, ok ? 0 : 1);
    check("R4 rdata", rdata, exp_rd);
    check("R10 lines released at done", {scl_line, sda_line}, 2'b11);
    check("R1 R5 byte count", n_log, n_exp);
    for (int i = 0; i < 3; i++)
      if (i < n_exp) check(r ? "R3 byte" : "R1 byte", log_b[i], eb[i]);
    check("R2 START count", starts, st_exp);
    check("R2 STOP count", stops, 1);
    check("R9 shortest SCL high", hmin, 2 * (dv + 1));
    check("R9 longest SCL high", hmax, 2 * (dv + 1));
    if (r && ok) begin
      check("R3 master ack count", n_mack, 2);
      check("R3 ACK after first byte", mack[0], 0);
      check("R3 NACK after last byte", mack[1], 1);
    end
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    if (inject) begin
      st_snap = starts;
      repeat (150) @(negedge clk);
      check("R7 no transfer from ignored start", busy, 0);
      check("R7 no extra START on bus", starts, st_snap);
    end
  endtask

  // global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; rnw = 0; dev = 0; regs = 0; wd = 0; clk_div = 16'd3;
    rd_src[0] = 0; rd_src[1] = 0;
    clr = 1;
    repeat (5) @(negedge clk);
    rst_n = 1; clr = 0;
    @(negedge clk);
    check("R10 reset busy", busy, 0);
    check("R10 reset done", done, 0);
    check("R10 reset nack_err", nack_err, 0);
    check("R10 reset rdata", rdata, 0);
    check("R10 bus released", {scl_oe, sda_oe}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      run_txn(v[46:43], v[42], v[41:35], v[34:28], v[27:19], v[18:11], v[10:3],
              int'(v[2:0]), 1'b0);
    end

    // R7: a second start during a write must be dropped
    run_txn(4'd3, 1'b0, 7'h1A, 7'h22, 9'h0F0, 8'h00, 8'h00, 7, 1'b1);
    // R6: error from a NACK clears at the following accepted start
    run_txn(4'd3, 1'b0, 7'h1A, 7'h22, 9'h0F0, 8'h00, 8'h00, 2, 1'b0);
    run_txn(4'd2, 1'b1, 7'h1A, 7'h01, 9'h000, 8'h01, 8'h00, 7, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule